// File: doc/BRIEF.md
# Immediate Saturating Shift-Narrow-Merge Unit

This unit takes two 256-bit vectors and shifts every element of both right by an immediate amount. It then saturates each element into a field half as wide. The first vector is a new source operand. The second is the current contents of the destination, which the unit reads as a second data source. Each 128-bit lane of the result is built from two halves:

- the lower 64 bits hold the narrowed elements of that lane of the source;
- the upper 64 bits hold the narrowed elements of the same lane of the old destination.

Every result bit is therefore written, and nothing is zeroed.

Source elements are 16, 32, 64 or 128 bits wide, so results are 8, 16, 32 or 64 bits wide. Two control bits select among four kinds of shift and saturation. The shift is logical or arithmetic. The clamp is either to a signed range or to an unsigned range. The complete result is formed from the inputs presented with the strobe, so every narrowing uses the destination value from before the operation. The result is registered one clock after the input strobe and is held until the next strobe.

Top module: `vec_narrow_imm`

## Requirements
- R1: After reset, `out_valid` and `result` are 0. `out_valid` is high on exactly the clock after each cycle in which `in_valid` is sampled high. `result` carries that operation's value from that same clock.
- R2: With `in_valid` low, `result` keeps its last value, whatever the other inputs do.
- R3: In each 128-bit lane k, result bits [128k+63:128k] hold the narrowed elements of `src_vec` lane k. Result bits [128k+127:128k+64] hold the narrowed elements of `dst_old` lane k. Element j of a half comes from element j of its lane, with the lowest element in the lowest bits.
- R4: `width_sel` selects the source element width: 0 = 16 bits, 1 = 32, 2 = 64, 3 = 128. The shift amount is `imm` bits [3:0], [4:0], [5:0] or [6:0] respectively, taken without any modulo. Higher `imm` bits are ignored. `shift_arith` = 1 selects an arithmetic shift and 0 a logical one. `sat_unsigned` = 1 selects the unsigned clamp and 0 the signed clamp.
- R5: A shift amount of zero passes each element unshifted into saturation.
- R6: Logical shift with signed clamp: the shifted value, read as unsigned, is limited to 2^(N-1)-1, where N is half the source width.
- R7: Arithmetic shift with signed clamp: the shifted signed value is limited to the range [-2^(N-1), 2^(N-1)-1].
- R8: Logical shift with unsigned clamp: the shifted value is limited to 2^N-1.
- R9: Arithmetic shift with unsigned clamp: an element that is negative before shifting gives 0. Otherwise the shifted value is limited to 2^N-1.
- R10: 128-bit sources narrow to 64-bit results under the same four rules. The limits are 2^63-1 for R6, [-2^63, 2^63-1] for R7, and 2^64-1 for R8 and R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation strobe |
| width_sel | input | 2 | Source element width code |
| shift_arith | input | 1 | 1 = arithmetic shift, 0 = logical |
| sat_unsigned | input | 1 | 1 = unsigned clamp, 0 = signed clamp |
| imm | input | 7 | Immediate shift amount |
| src_vec | input | 256 | Source operand |
| dst_old | input | 256 | Current destination contents |
| out_valid | output | 1 | Result strobe |
| result | output | 256 | Registered narrowed and merged vector |

## Verification
Every result is due one clock after its strobe. The bench drives inputs on the falling edge and raises `in_valid` for a single cycle. On the next falling edge it compares `out_valid` and the full 256-bit `result`. One falling edge later it confirms that `out_valid` has dropped, and after further idle cycles with changed operands it confirms that `result` has not moved. Expected vectors come from a bench-side model that sign- or zero-extends, shifts and clamps each element with wide integer arithmetic. Hand-written literals cover the extreme values of each clamp kind.

// File: rtl/narrow_pkg.sv
package narrow_pkg;
  localparam int VEC_W  = 256;
  localparam int LANE_W = 128;
  localparam int IMM_W  = 7;
  localparam int NUM_WIDTHS = 4;

  typedef enum logic [1:0] {
    EW16  = 2'd0,
    EW32  = 2'd1,
    EW64  = 2'd2,
    EW128 = 2'd3
  } elemWidth_e;

  typedef struct packed {
    logic             load;
    elemWidth_e       width;
    logic             arith;
    logic             unsat;
    logic [IMM_W-1:0] shamt;
  } nrwStrobe_t;
endpackage

// File: rtl/nrw_elem.sv
module nrw_elem #(
  parameter int W = 16
) (
  input  logic [W-1:0]         inVal,
  input  logic [$clog2(W)-1:0] shAmt,
  input  logic                 arith,
  input  logic                 unsat,
  output logic [W/2-1:0]       outVal
);
  localparam int N = W / 2;

  logic [W-1:0] arShifted;
  logic [W-1:0] lgShifted;
  logic [W-1:0] shifted;

  always_comb begin
    arShifted = $signed(inVal) >>> shAmt;
    lgShifted = inVal >> shAmt;
    shifted   = arith ? arShifted : lgShifted;
    outVal    = shifted[N-1:0];
    unique case ({arith, unsat})
      2'b00: begin
        if (|shifted[W-1:N-1]) outVal = {1'b0, {(N-1){1'b1}}};
      end
      2'b10: begin
        if (shifted[W-1:N-1] != {(N+1){shifted[W-1]}})
          outVal = shifted[W-1] ? {1'b1, {(N-1){1'b0}}} : {1'b0, {(N-1){1'b1}}};
      end
      default: begin
        if (arith && inVal[W-1]) outVal = '0;
        else if (|shifted[W-1:N]) outVal = '1;
      end
    endcase
  end

  // Checks on the combinational result
  always_comb begin
    if (arith && unsat && inVal[W-1]) begin
      p_neg_to_zero_r9: assert (outVal == '0);
    end
    if (!arith && !unsat) begin
      p_logic_signed_top_r6: assert (!outVal[N-1]);
    end
  end
endmodule

// File: rtl/nrw_ctrl.sv
module nrw_ctrl
  import narrow_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic [1:0]       widthSel,
  input  logic             shiftArith,
  input  logic             satUnsigned,
  input  logic [IMM_W-1:0] immVal,
  output nrwStrobe_t       strb,
  output logic             outValid
);
  always_comb begin
    strb.load  = inValid;
    strb.width = elemWidth_e'(widthSel);
    strb.arith = shiftArith;
    strb.unsat = satUnsigned;
    strb.shamt = immVal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);
endmodule

// File: rtl/nrw_datapath.sv
module nrw_datapath
  import narrow_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  nrwStrobe_t       strb,
  input  logic [VEC_W-1:0] srcVec,
  input  logic [VEC_W-1:0] dstOld,
  output logic [VEC_W-1:0] resultQ
);
  localparam int NUM_LANES = VEC_W / LANE_W;
  localparam int CAT_W     = 2 * VEC_W;

  logic [CAT_W-1:0] catIn;
  logic [NUM_WIDTHS-1:0][VEC_W-1:0] narrowed;

  // Lane k of the concatenation: source lane in the low half, old destination in the high half
  for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
    assign catIn[ln*2*LANE_W +: LANE_W]          = srcVec[ln*LANE_W +: LANE_W];
    assign catIn[ln*2*LANE_W + LANE_W +: LANE_W] = dstOld[ln*LANE_W +: LANE_W];
  end

  for (genvar gw = 0; gw < NUM_WIDTHS; gw++) begin : g_width
    localparam int EW = 16 << gw;
    localparam int EN = EW / 2;
    localparam int NE = CAT_W / EW;
    localparam int SW = $clog2(EW);
    for (genvar e = 0; e < NE; e++) begin : g_elem
      nrw_elem #(.W(EW)) u_elem (
        .inVal (catIn[e*EW +: EW]),
        .shAmt (strb.shamt[SW-1:0]),
        .arith (strb.arith),
        .unsat (strb.unsat),
        .outVal(narrowed[gw][e*EN +: EN])
      );
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         resultQ <= '0;
    else if (strb.load) resultQ <= narrowed[strb.width];
  end

  p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.load |=> $stable(resultQ));
endmodule

// File: rtl/vec_narrow_imm.sv
module vec_narrow_imm
  import narrow_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       width_sel,
  input  logic             shift_arith,
  input  logic             sat_unsigned,
  input  logic [IMM_W-1:0] imm,
  input  logic [VEC_W-1:0] src_vec,
  input  logic [VEC_W-1:0] dst_old,
  output logic             out_valid,
  output logic [VEC_W-1:0] result
);
  nrwStrobe_t strb;

  nrw_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .inValid    (in_valid),
    .widthSel   (width_sel),
    .shiftArith (shift_arith),
    .satUnsigned(sat_unsigned),
    .immVal     (imm),
    .strb       (strb),
    .outValid   (out_valid)
  );

  nrw_datapath u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb   (strb),
    .srcVec (src_vec),
    .dstOld (dst_old),
    .resultQ(result)
  );
endmodule

// File: tb/test_vec_narrow_imm.sv
module test_vec_narrow_imm;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] width_sel = '0;
  logic shift_arith = 1'b0;
  logic sat_unsigned = 1'b0;
  logic [6:0] imm = '0;
  logic [255:0] src_vec = '0;
  logic [255:0] dst_old = '0;
  logic out_valid;
  logic [255:0] result;

  int checks = 0;
  int fails = 0;
  logic [63:0] seed = 64'h1234_5678_9abc_def1;

  always #10 clk = ~clk;

  vec_narrow_imm i_vec_narrow_imm (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .width_sel(width_sel),
    .shift_arith(shift_arith), .sat_unsigned(sat_unsigned), .imm(imm),
    .src_vec(src_vec), .dst_old(dst_old), .out_valid(out_valid), .result(result)
  );

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 4; i++) begin
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 7);
      seed = seed ^ (seed << 17);
      v[i*64 +: 64] = seed;
    end
    return v;
  endfunction

  // Model of one element: extend, shift, clamp, keep n bits
  function automatic logic [63:0] refElem(logic [127:0] x, int w, int s, bit ar, bit us);
    logic signed [129:0] v, hi, lo;
    logic [63:0] r;
    int n;
    n = w / 2;
    for (int b = 0; b < 130; b++) v[b] = (b < w) ? x[b] : (ar ? x[w-1] : 1'b0);
    v = v >>> s;
    hi = us ? ((130'sd1 <<< n) - 130'sd1) : ((130'sd1 <<< (n-1)) - 130'sd1);
    lo = (us || !ar) ? 130'sd0 : -(130'sd1 <<< (n-1));
    if (v > hi) v = hi;
    if (v < lo) v = lo;
    r = '0;
    for (int b = 0; b < n; b++) r[b] = v[b];
    return r;
  endfunction

  function automatic logic [255:0] refVec(logic [255:0] sv, logic [255:0] dv, int ws,
                                          bit ar, bit us, int im);
    logic [255:0] res;
    logic [127:0] xs, xd;
    logic [63:0] rs, rd;
    int w, n, s;
    w = 16 << ws;
    n = w / 2;
    s = im & (w - 1);
    res = '0;
    for (int ln = 0; ln < 2; ln++) begin
      for (int k = 0; k < 128 / w; k++) begin
        xs = '0; xd = '0;
        for (int b = 0; b < w; b++) begin
          xs[b] = sv[ln*128 + k*w + b];
          xd[b] = dv[ln*128 + k*w + b];
        end
        rs = refElem(xs, w, s, ar, us);
        rd = refElem(xd, w, s, ar, us);
        for (int b = 0; b < n; b++) begin
          res[ln*128 + k*n + b]      = rs[b];
          res[ln*128 + 64 + k*n + b] = rd[b];
        end
      end
    end
    return res;
  endfunction

  task automatic check(string req, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one operation; returns after the result clock, at a falling edge
  task automatic runOp(int ws, bit ar, bit us, int im, logic [255:0] sv, logic [255:0] dv);
    @(negedge clk);
    width_sel = 2'(ws); shift_arith = ar; sat_unsigned = us; imm = 7'(im);
    src_vec = sv; dst_old = dv; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic opCheck(string req, int ws, bit ar, bit us, int im,
                         logic [255:0] sv, logic [255:0] dv);
    runOp(ws, ar, us, im, sv, dv);
    check({req, " valid"}, {255'b0, out_valid}, 256'd1);
    check(req, result, refVec(sv, dv, ws, ar, us, im));
  endtask

  task automatic t_reset();
    check("R1 reset valid", {255'b0, out_valid}, '0);
    check("R1 reset result", result, '0);
  endtask

  task automatic t_timing();
    runOp(1, 0, 1, 3, rnd256(), rnd256());
    check("R1 valid one cycle", {255'b0, out_valid}, 256'd1);
    @(negedge clk);
    check("R1 valid drops", {255'b0, out_valid}, '0);
  endtask

  task automatic t_hold();
    logic [255:0] held;
    logic [255:0] s0, d0;
    s0 = rnd256(); d0 = rnd256();
    runOp(0, 1, 0, 2, s0, d0);
    held = result;
    check("R2 held value", held, refVec(s0, d0, 0, 1, 0, 2));
    width_sel = 2'd3; imm = 7'd5; src_vec = rnd256(); dst_old = rnd256();
    repeat (3) @(negedge clk);
    check("R2 result unchanged", result, held);
  endtask

  task automatic t_layout();
    logic [255:0] s0, d0, e0;
    s0 = {64'h44, 64'h33, 64'h22, 64'h11};
    d0 = {64'hdd, 64'hcc, 64'hbb, 64'haa};
    e0 = {32'hdd, 32'hcc, 32'h44, 32'h33, 32'hbb, 32'haa, 32'h22, 32'h11};
    runOp(2, 0, 1, 0, s0, d0);
    check("R3 lane layout", result, e0);
  endtask

  task automatic t_imm_mask();
    logic [255:0] s0, d0, r0;
    s0 = rnd256(); d0 = rnd256();
    runOp(0, 0, 1, 7'h03, s0, d0);
    r0 = result;
    runOp(0, 0, 1, 7'h73, s0, d0);
    check("R4 upper imm bits ignored w16", result, r0);
    check("R4 shift 3 w16", r0, refVec(s0, d0, 0, 0, 1, 3));
    opCheck("R4 imm 31 w32", 1, 1, 0, 7'h7f, rnd256(), rnd256());
    opCheck("R4 imm 63 w64", 2, 0, 0, 7'h7f, rnd256(), rnd256());
  endtask

  task automatic t_zero_imm();
    logic [255:0] s0;
    s0 = {16{16'h0042}};
    runOp(0, 0, 0, 0, s0, s0);
    check("R5 zero shift passthrough", result, {32{8'h42}});
  endtask

  task automatic t_kinds();
    // R6: logical signed, 16-bit 0x7FFF clamps to 0x7F
    runOp(0, 0, 0, 0, {16{16'h7fff}}, '0);
    check("R6 logical signed clamp", result,
          {64'h0, 64'h7f7f7f7f7f7f7f7f, 64'h0, 64'h7f7f7f7f7f7f7f7f});
    for (int ws = 0; ws < 3; ws++) opCheck("R6 random", ws, 0, 0, ws * 3 + 1, rnd256(), rnd256());
    // R7: arithmetic signed
    runOp(0, 1, 0, 0, {16{16'h8000}}, {16{16'hff80}});
    check("R7 arith signed clamp", result,
          {64'h8080808080808080, 64'h8080808080808080, 64'h8080808080808080, 64'h8080808080808080});
    for (int ws = 0; ws < 3; ws++) opCheck("R7 random", ws, 1, 0, ws + 2, rnd256(), rnd256());
    // R8: logical unsigned
    runOp(1, 0, 1, 0, {8{32'h8000_0000}}, {8{32'h0000_1234}});
    check("R8 logical unsigned clamp", result,
          {64'h1234_1234_1234_1234, 64'hffff_ffff_ffff_ffff, 64'h1234_1234_1234_1234, 64'hffff_ffff_ffff_ffff});
    for (int ws = 0; ws < 3; ws++) opCheck("R8 random", ws, 0, 1, ws * 5, rnd256(), rnd256());
    // R9: arithmetic unsigned, negatives give zero
    runOp(1, 1, 1, 0, {8{32'h8000_0000}}, {8{32'h0001_0000}});
    check("R9 arith unsigned", result,
          {64'hffff_ffff_ffff_ffff, 64'h0, 64'hffff_ffff_ffff_ffff, 64'h0});
    for (int ws = 0; ws < 3; ws++) opCheck("R9 random", ws, 1, 1, ws + 1, rnd256(), rnd256());
  endtask

  task automatic t_q128();
    runOp(3, 1, 0, 0, {128'h1_0000_0000_0000_0000, 128'h8000_0000_0000_0000_0000_0000_0000_0000},
          {{128{1'b1}}, 128'h5});
    check("R10 128-bit arith signed", result,
          {64'hffff_ffff_ffff_ffff, 64'h7fff_ffff_ffff_ffff, 64'h5, 64'h8000_0000_0000_0000});
    runOp(3, 0, 0, 64, {256{1'b1}}, '0);
    check("R10 128-bit logical signed", result,
          {64'h0, 64'h7fff_ffff_ffff_ffff, 64'h0, 64'h7fff_ffff_ffff_ffff});
    runOp(3, 1, 1, 1, {128'h8000_0000_0000_0000_0000_0000_0000_0001, 128'h3_0000_0000_0000_0000},
          {128'h0, 128'h1_0000_0000_0000_0002});
    check("R10 128-bit arith unsigned", result,
          {64'h0, 64'h0, 64'h8000_0000_0000_0001, 64'hffff_ffff_ffff_ffff});
    opCheck("R10 128-bit logical unsigned", 3, 0, 1, 100, rnd256(), rnd256());
    opCheck("R10 128-bit random arith", 3, 1, 0, 70, rnd256(), rnd256());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_timing();
    t_hold();
    t_layout();
    t_imm_mask();
    t_zero_imm();
    t_kinds();
    t_q128();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule